// File: doc/BRIEF.md
# Program/Erase Permission and Suspend Controller

This block sits behind the serial command decoder of a flash memory. Each decoded command reaches it as a one-cycle strobe carrying the opcode and the array address. The block then decides whether a program, block erase, chip erase, suspend or resume may go ahead. To decide, it checks four things:

- the write-enable latch;
- the protect and lockdown state of the addressed 64 KB sector, which it looks up over a side port;
- whether any sector is guarded, for chip erase;
- which operations are suspended at the moment.

It starts, suspends and resumes a modeled array engine through single-cycle pulses and takes a done/fail handshake back from it. It also keeps a five-bit status word.

Status bits:

| Bit | Meaning |
|-----|---------|
| 0 | busy |
| 1 | write-enable latch |
| 2 | erase suspended |
| 3 | program suspended |
| 4 | program/erase error |
| 7:5 | read as 0 |

Opcodes used:

| Opcode | Command |
|--------|---------|
| 06h | write enable |
| 04h | write disable |
| 02h, A2h | program |
| 20h, 52h, D8h | block erase of 4 KB, 32 KB, 64 KB |
| 60h, C7h | chip erase |
| B0h | suspend |
| D0h | resume |

The sector index is address bits [20:16]. The engine operation code is 0 for program, 1 for block erase and 2 for chip erase. Every command takes effect on the clock edge that samples its strobe. The status word and engine pulses show the result in the following cycle.

Top module: `flash_op_gate`

## Requirements
- R1: After reset the status word is 00h. Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears it.
- R2: A program, block erase or chip erase sent while the latch is 0 starts nothing and leaves the status word unchanged.
- R3: An accepted program or erase pulses eng_start for one cycle and sets busy. In the same cycle it clears the write-enable latch and the error bit (bit 4).
- R4: Block erase 20h, 52h and D8h passes the address with bits 11:0, 14:0 and 15:0 zeroed, and eng_op is 1. Chip erase 60h and C7h behave the same: address 0 and eng_op 2. Program passes the address unchanged, and eng_op is 0.
- R5: A program or block erase whose sector is protected or locked starts nothing and clears the latch. So does a chip erase while any sector is guarded.
- R6: An abort strobe from the decoder, for an incomplete frame, clears the latch while the block is not busy.
- R7: Suspend (B0h) during a program sets bit 3, and during a block erase sets bit 2. Busy drops and the latch is unchanged. Suspend while idle, or during a chip erase, is ignored.
- R8: A program to the erase-suspended sector, or a block erase to the program-suspended sector, starts nothing and clears the latch.
- R9: While an erase is suspended, a program to another sector may start. Suspending that program leaves bits 2 and 3 both set.
- R10: Resume (D0h) restarts the suspended program first and then the suspended erase. Each resume pulses eng_resume, clears the matching suspend bit and sets busy. With nothing suspended, resume is ignored.
- R11: While an operation is suspended, commands other than 06h, 04h, program, suspend and resume (for example 36h), and block erase to any other sector, leave the status word unchanged.
- R12: eng_done with eng_fail sets the error bit, and busy drops. eng_done without eng_fail leaves the error bit at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | decoded command strobe |
| cmd_abort | input | 1 | malformed program/erase frame strobe |
| cmd_op | input | 8 | opcode |
| cmd_addr | input | ARR_W | array address |
| lk_sector | output | SECT_W | sector index for the protection lookup |
| lk_prot | input | 1 | looked-up sector is protected |
| lk_lock | input | 1 | looked-up sector is locked down |
| any_guard | input | 1 | some sector is protected or locked |
| eng_start | output | 1 | engine start pulse |
| eng_op | output | 2 | engine operation: 0 program, 1 block erase, 2 chip erase |
| eng_addr | output | ARR_W | engine start address, aligned for erase |
| eng_suspend | output | 1 | engine suspend pulse |
| eng_resume | output | 1 | engine resume pulse |
| eng_done | input | 1 | engine finished the current operation |
| eng_fail | input | 1 | engine reports a failure, qualified by eng_done |
| status | output | 8 | status word |

## Verification
A wrong internal state shows at the ports one cycle after the command that exposes it. A stale suspended-sector number lets a conflicting program or erase start, so eng_start pulses when it must not. A wrong suspend order makes the first resume clear bit 2 instead of bit 3, which is visible in the status word at once. A mishandled latch shows either as an unexpected start or as bit 1 set when it should not be. Random block and chip erases, with protection chosen at random, check the address alignment and the protection refusal against a model in the bench.

// File: rtl/flash_op_gate.sv
module flash_op_gate #(
  parameter int ARR_W    = 21,
  parameter int SECT_LSB = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic                       cmd_abort,
  input  logic [7:0]                 cmd_op,
  input  logic [ARR_W-1:0]           cmd_addr,
  output logic [ARR_W-SECT_LSB-1:0]  lk_sector,
  input  logic                       lk_prot,
  input  logic                       lk_lock,
  input  logic                       any_guard,
  output logic                       eng_start,
  output logic [1:0]                 eng_op,
  output logic [ARR_W-1:0]           eng_addr,
  output logic                       eng_suspend,
  output logic                       eng_resume,
  input  logic                       eng_done,
  input  logic                       eng_fail,
  output logic [7:0]                 status
);
  localparam int SECT_W = ARR_W - SECT_LSB;
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_PROG = 8'h02, OP_PROG2 = 8'hA2;
  localparam logic [7:0] OP_E4 = 8'h20, OP_E32 = 8'h52, OP_E64 = 8'hD8;
  localparam logic [7:0] OP_CE = 8'h60, OP_CE2 = 8'hC7, OP_SUSP = 8'hB0, OP_RES = 8'hD0;
  localparam logic [1:0] K_PROG = 2'd0, K_BLK = 2'd1, K_CHIP = 2'd2;

  logic busy, wel, es, ps, epe;
  logic [1:0] cur;
  logic [SECT_W-1:0] act_sec, es_sec, ps_sec;

  logic is_prog, is_blk, is_chip, guarded;
  logic [SECT_W-1:0] sect;
  logic [ARR_W-1:0] blk_mask;

  assign sect      = cmd_addr[ARR_W-1:SECT_LSB];
  assign lk_sector = sect;
  assign is_prog   = (cmd_op == OP_PROG) || (cmd_op == OP_PROG2);
  assign is_blk    = (cmd_op == OP_E4) || (cmd_op == OP_E32) || (cmd_op == OP_E64);
  assign is_chip   = (cmd_op == OP_CE) || (cmd_op == OP_CE2);
  assign guarded   = lk_prot | lk_lock;
  assign eng_op    = cur;
  assign status    = {3'b000, epe, ps, es, wel, busy};

  always_comb begin
    case (cmd_op)
      OP_E4:   blk_mask = {ARR_W{1'b1}} << 12;
      OP_E32:  blk_mask = {ARR_W{1'b1}} << 15;
      default: blk_mask = {ARR_W{1'b1}} << 16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; wel <= 1'b0; es <= 1'b0; ps <= 1'b0; epe <= 1'b0;
      cur <= K_PROG; act_sec <= '0; es_sec <= '0; ps_sec <= '0;
      eng_start <= 1'b0; eng_suspend <= 1'b0; eng_resume <= 1'b0; eng_addr <= '0;
    end else begin
      eng_start <= 1'b0; eng_suspend <= 1'b0; eng_resume <= 1'b0;
      if (busy) begin
        if (eng_done) begin
          busy <= 1'b0;
          if (eng_fail) epe <= 1'b1;
        end else if (cmd_valid && !cmd_abort && cmd_op == OP_SUSP && cur != K_CHIP) begin
          busy <= 1'b0;
          eng_suspend <= 1'b1;
          if (cur == K_PROG) begin ps <= 1'b1; ps_sec <= act_sec; end
          else begin es <= 1'b1; es_sec <= act_sec; end
        end
      end else if (cmd_abort) begin
        wel <= 1'b0;
      end else if (cmd_valid) begin
        if (cmd_op == OP_WREN) wel <= 1'b1;
        else if (cmd_op == OP_WRDI) wel <= 1'b0;
        else if (is_prog && wel && !ps) begin
          if (guarded || (es && sect == es_sec)) wel <= 1'b0;
          else begin
            busy <= 1'b1; wel <= 1'b0; epe <= 1'b0; eng_start <= 1'b1;
            cur <= K_PROG; act_sec <= sect; eng_addr <= cmd_addr;
          end
        end else if (is_blk && wel && !es) begin
          if (ps) begin
            if (sect == ps_sec) wel <= 1'b0;
          end else if (guarded) wel <= 1'b0;
          else begin
            busy <= 1'b1; wel <= 1'b0; epe <= 1'b0; eng_start <= 1'b1;
            cur <= K_BLK; act_sec <= sect; eng_addr <= cmd_addr & blk_mask;
          end
        end else if (is_chip && wel && !es && !ps) begin
          if (any_guard) wel <= 1'b0;
          else begin
            busy <= 1'b1; wel <= 1'b0; epe <= 1'b0; eng_start <= 1'b1;
            cur <= K_CHIP; eng_addr <= '0;
          end
        end else if (cmd_op == OP_RES) begin
          if (ps) begin
            ps <= 1'b0; busy <= 1'b1; eng_resume <= 1'b1; cur <= K_PROG; act_sec <= ps_sec;
          end else if (es) begin
            es <= 1'b0; busy <= 1'b1; eng_resume <= 1'b1; cur <= K_BLK; act_sec <= es_sec;
          end
        end
      end
    end
  end

  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(wel));
  p_suspend_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend |-> (!busy && (ps || es) && wel == $past(wel)));
  p_no_conflict_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_op == K_PROG && es) |-> (eng_addr[ARR_W-1:SECT_LSB] != es_sec));
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_suspend, eng_resume}));
  p_fail_sets_epe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_fail) |=> (epe && !busy));
endmodule

// File: tb/flash_op_gate_tb.sv
module flash_op_gate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_abort = 0, lk_prot = 0, lk_lock = 0, any_guard = 0;
  logic eng_done = 0, eng_fail = 0;
  logic [7:0] cmd_op = 0;
  logic [20:0] cmd_addr = 0;
  logic [4:0] lk_sector;
  logic eng_start, eng_suspend, eng_resume;
  logic [1:0] eng_op;
  logic [20:0] eng_addr;
  logic [7:0] status;
  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  flash_op_gate dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_abort(cmd_abort),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .lk_sector(lk_sector), .lk_prot(lk_prot),
    .lk_lock(lk_lock), .any_guard(any_guard), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
    .eng_done(eng_done), .eng_fail(eng_fail), .status(status));

  function automatic logic [7:0] st(bit b, bit w, bit e, bit p, bit x);
    return {3'b000, x, p, e, w, b};
  endfunction

  function automatic logic [20:0] exp_addr(logic [7:0] op, logic [20:0] a);
    case (op)
      8'h20: return {a[20:12], 12'h000};
      8'h52: return {a[20:15], 15'h0000};
      8'hD8: return {a[20:16], 16'h0000};
      8'h60, 8'hC7: return 21'h0;
      default: return a;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] op, logic [20:0] a, bit prot = 0, bit lock = 0, bit anyg = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; lk_prot = prot; lk_lock = lock; any_guard = anyg;
    @(negedge clk);
    cmd_valid = 0; lk_prot = 0; lk_lock = 0; any_guard = 0;
  endtask

  task automatic fin(bit fail);
    @(negedge clk); eng_done = 1; eng_fail = fail;
    @(negedge clk); eng_done = 0; eng_fail = 0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    cmd(8'h06, 0); chk("R1 wren", status, st(0,1,0,0,0));
    cmd(8'h04, 0); chk("R1 wrdi", status, st(0,0,0,0,0));

    cmd(8'h02, 21'h12345); chk("R2 no wel start", eng_start, 0);
    chk("R2 no wel status", status, 8'h00);
    cmd(8'hC7, 0); chk("R2 chip no wel", eng_start, 0);

    cmd(8'h06, 0); cmd(8'h02, 21'h12345);
    chk("R3 start pulse", eng_start, 1); chk("R3 busy no wel", status, st(1,0,0,0,0));
    chk("R4 prog addr", eng_addr, 21'h12345); chk("R4 prog op", eng_op, 0);
    cmd(8'h06, 0); chk("R11 wren ignored when busy", status, st(1,0,0,0,0));
    fin(0); chk("R12 done ok", status, 8'h00);
    cmd(8'h06, 0); cmd(8'hA2, 21'h00100); fin(1);
    chk("R12 fail sets error", status, st(0,0,0,0,1));
    cmd(8'h06, 0); cmd(8'h02, 21'h00200);
    chk("R3 start clears error", status, st(1,0,0,0,0)); fin(0);

    cmd(8'h06, 0); cmd(8'h02, 21'h30000, 1, 0);
    chk("R5 prot prog no start", eng_start, 0); chk("R5 prot prog wel", status, 8'h00);
    cmd(8'h06, 0); cmd(8'h20, 21'h30000, 0, 1);
    chk("R5 lock erase", status, 8'h00);
    cmd(8'h06, 0); cmd(8'h60, 0, 0, 0, 1);
    chk("R5 chip guarded", status, 8'h00);
    cmd(8'h06, 0);
    @(negedge clk); cmd_abort = 1; @(negedge clk); cmd_abort = 0;
    chk("R6 abort clears wel", status, 8'h00);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] ops [5] = '{8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7};
      logic [7:0] op = ops[$urandom_range(0, 4)];
      logic [20:0] a = 21'($urandom);
      bit g = ($urandom_range(0, 3) == 0);
      bit chip = (op == 8'h60 || op == 8'hC7);
      cmd(8'h06, 0);
      if (chip) cmd(op, a, 0, 0, g); else cmd(op, a, g, 0, 0);
      chk("R5 random start", eng_start, !g);
      chk("R5 random status", status, g ? st(0,0,0,0,0) : st(1,0,0,0,0));
      if (!g) begin
        chk("R4 random addr", eng_addr, exp_addr(op, a));
        chk("R4 random op", eng_op, chip ? 2 : 1);
        fin(0);
      end
    end

    cmd(8'h06, 0); cmd(8'hB0, 0);
    chk("R7 idle suspend ignored", status, st(0,1,0,0,0));
    cmd(8'h02, 21'h40010); cmd(8'hB0, 0);
    chk("R7 suspend pulse", eng_suspend, 1); chk("R7 ps ready", status, st(0,0,0,1,0));
    cmd(8'h36, 21'h40010); chk("R11 36h ignored", status, st(0,0,0,1,0));
    cmd(8'h06, 0); chk("R11 wren in suspend", status, st(0,1,0,1,0));
    cmd(8'h20, 21'h10000); chk("R11 erase other sector ignored", status, st(0,1,0,1,0));
    cmd(8'h36, 0); chk("R11 36h wel kept", status, st(0,1,0,1,0));
    cmd(8'hD8, 21'h4F000); chk("R8 erase ps sector", eng_start, 0);
    chk("R8 erase ps sector wel", status, st(0,0,0,1,0));
    cmd(8'hD0, 0); chk("R10 resume prog", eng_resume, 1);
    chk("R10 resume status", status, st(1,0,0,0,0)); fin(0);

    cmd(8'h06, 0); cmd(8'hD8, 21'h31234);
    chk("R4 erase addr", eng_addr, 21'h30000);
    cmd(8'hB0, 0); chk("R7 es ready", status, st(0,0,1,0,0));
    cmd(8'h06, 0); cmd(8'h02, 21'h3ABCD);
    chk("R8 prog es sector", eng_start, 0); chk("R8 prog es wel", status, st(0,0,1,0,0));
    cmd(8'h06, 0); cmd(8'h02, 21'h50004);
    chk("R9 prog other sector", eng_start, 1); chk("R9 busy in es", status, st(1,0,1,0,0));
    cmd(8'hB0, 0); chk("R9 both suspended", status, st(0,0,1,1,0));
    cmd(8'hD0, 0); chk("R10 ps first", status, st(1,0,1,0,0)); chk("R10 prog op", eng_op, 0);
    fin(0); chk("R10 prog done", status, st(0,0,1,0,0));
    cmd(8'hD0, 0); chk("R10 es second", status, st(1,0,0,0,0)); chk("R10 erase op", eng_op, 1);
    fin(0);
    cmd(8'hD0, 0); chk("R10 empty resume", eng_resume, 0); chk("R10 empty status", status, 8'h00);

    cmd(8'h06, 0); cmd(8'h60, 0); cmd(8'hB0, 0);
    chk("R7 chip suspend ignored", eng_suspend, 0); chk("R7 chip busy", status, st(1,0,0,0,0));
    fin(0);
    summary();
  end
endmodule